// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

The receiver takes PCM audio over a three-wire serial link (bit clock, frame sync, data) and delivers each finished word as a left-justified 24-bit sample. The sample comes with a one-cycle strobe, a left/right flag and the three side-channel bits (channel status, user, validity) that were sampled during that word. All pins are oversampled in the `clk_i` domain. A bit-clock edge is therefore an event between two `clk_i` cycles, and both serial clocks must run well below `clk_i` (at least two `clk_i` cycles per bit-clock phase).

A 3-bit format code picks one of seven framings. Format 0 makes the block the clock master: it generates the bit clock and the frame sync from `clk_i`. Format 2 is a word-clock framing, where only the rising frame-sync edge opens a word. Format 4 is I2S-like. Formats 5 and 6 are right-justified at 16 and 18 bits. Format 7 sends the LSB first and the MSB last. The output register is loaded only when a word completes, so the consumer always reads a stable sample while the next word shifts in. If the length of a word differs from the length of the word before it by at least four clock cycles, the frame sync is treated as having slipped, and that word is not delivered.

Top module: `audin_port`

## Requirements
- R1: With format 0, `drive_en_o` is 1 and `sck_o` runs at a period of 4 `clk_i` cycles. `fs_o` toggles only together with a falling `sck_o`, once every 32 `sck_o` periods (high = left). With any other format `drive_en_o` is 0 and the pins `sck_i`/`fs_i` are used.
- R2: Formats 0, 1, 2 and 4 sample data and frame sync on the rising bit-clock edge. Formats 5, 6 and 7 sample them on the falling edge.
- R3: In formats 0, 1 and 2 the MSB is the first bit sampled after a frame-sync change. Only the first 24 bits are kept and later bits are ignored. A word of fewer than 24 bits is zero-filled in the low bits.
- R4: In format 4 the first bit after the frame-sync change is ignored and the MSB is the second bit. Frame sync low marks the left word.
- R5: Formats 5 and 6 take the last 16 or 18 bits before the next frame-sync change and place them at the top of `word_o`, with zeros in the bits below.
- R6: Format 7 receives the LSB first. It keeps the last 24 bits before the next frame-sync change, and the final bit becomes `word_o[23]`.
- R7: In format 2 only a rising frame sync opens a word, and a falling frame sync is ignored. The left/right flag alternates, and the first delivered word after reset is left.
- R8: Format 3 is reserved and never raises `word_valid_o`.
- R9: A word is delivered when the frame-sync change that opens the next word is sampled. `word_valid_o` is then high for one cycle, and `word_o`, `left_o` and `c_o`/`u_o`/`v_o` hold until the next strobe. The partial word running at reset exit is not delivered. Outside formats 2 and 4, `left_o` is the frame-sync level during the word (high = left).
- R10: `c_i`, `u_i` and `v_i` are sampled in the first bit period of a word, or the second in format 4. The sampled values are delivered with that word.
- R11: A word whose duration, measured in `clk_i` cycles between opening edges, differs by 4 or more from the previous word's duration is not delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Format code 0..7 |
| sck_i | input | 1 | Bit clock when slave |
| fs_i | input | 1 | Frame sync when slave |
| sd_i | input | 1 | Serial data |
| c_i | input | 1 | Channel-status side bit |
| u_i | input | 1 | User side bit |
| v_i | input | 1 | Validity side bit |
| sck_o | output | 1 | Generated bit clock (format 0) |
| fs_o | output | 1 | Generated frame sync (format 0) |
| drive_en_o | output | 1 | High when `sck_o`/`fs_o` should drive the pins |
| word_o | output | 24 | Last delivered sample, left-justified |
| left_o | output | 1 | Delivered sample is left channel |
| c_o | output | 1 | Channel-status bit of delivered sample |
| u_o | output | 1 | User bit of delivered sample |
| v_o | output | 1 | Validity bit of delivered sample |
| word_valid_o | output | 1 | One-cycle strobe for a new sample |

## Verification
Every pin passes through one input register before edge detection. A strobe therefore rises on the second `clk_i` edge after the pin transition that forms the active bit-clock edge of the next word's first bit. In format 0 the same count applies, starting from `sck_o`. The bench records every strobe and its payload on falling `clk_i` edges, sends one extra slot after each word it wants to see, and compares the recorded sequence afterwards, so no result depends on the exact strobe cycle. Within each bit, data is valid only around the active edge and is inverted after it, which exposes sampling on the wrong edge. Side-channel pins are pulsed in single bit periods to pin down which period is sampled.

// File: rtl/audin_pkg.sv
package audin_pkg;
  typedef enum logic [2:0] {
    FMT_MSTR = 3'd0,
    FMT_LJ   = 3'd1,
    FMT_WCLK = 3'd2,
    FMT_RSVD = 3'd3,
    FMT_I2S  = 3'd4,
    FMT_RJ16 = 3'd5,
    FMT_RJ18 = 3'd6,
    FMT_LSBF = 3'd7
  } fmt_e;

  typedef struct packed {
    logic c;
    logic u;
    logic v;
  } side_t;
endpackage

// File: rtl/audin_mstr_gen.sv
module audin_mstr_gen #(
  parameter int HALF = 2,
  parameter int SLOT = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic sck_o,
  output logic fs_o
);
  localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int SW = $clog2(SLOT);

  logic [HW-1:0] hcnt_q;
  logic [SW-1:0] bcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q <= '0;
      bcnt_q <= '0;
      sck_o  <= 1'b0;
      fs_o   <= 1'b0;
    end else if (!en_i) begin
      hcnt_q <= '0;
      bcnt_q <= '0;
      sck_o  <= 1'b0;
      fs_o   <= 1'b0;
    end else if (hcnt_q == HW'(HALF - 1)) begin
      hcnt_q <= '0;
      sck_o  <= ~sck_o;
      if (sck_o) begin
        if (bcnt_q == SW'(SLOT - 1)) begin
          bcnt_q <= '0;
          fs_o   <= ~fs_o;
        end else begin
          bcnt_q <= bcnt_q + 1'b1;
        end
      end
    end else begin
      hcnt_q <= hcnt_q + 1'b1;
    end
  end

  // R1
  fs_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && !$stable(fs_o)) |-> $fell(sck_o));
endmodule

// File: rtl/audin_jit_mon.sv
module audin_jit_mon #(
  parameter int GW  = 10,
  parameter int TOL = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bnd_i,
  input  logic busy_i,
  output logic drop_o
);
  logic [GW-1:0] gap_q, ref_q, diff;
  logic          ref_ok_q;

  always_comb begin
    diff   = (gap_q > ref_q) ? (gap_q - ref_q) : (ref_q - gap_q);
    drop_o = bnd_i & busy_i & ref_ok_q & (diff >= GW'(TOL));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q    <= '0;
      ref_q    <= '0;
      ref_ok_q <= 1'b0;
    end else if (bnd_i) begin
      gap_q <= '0;
      if (busy_i) begin
        ref_q    <= gap_q;
        ref_ok_q <= 1'b1;
      end
    end else if (!(&gap_q)) begin
      gap_q <= gap_q + 1'b1;
    end
  end
endmodule

// File: rtl/audin_deser.sv
module audin_deser
  import audin_pkg::*;
#(
  parameter int DW    = 24,
  parameter int RJ_A  = 16,
  parameter int RJ_B  = 18,
  parameter int SLACK = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  fmt_e          mode_i,
  input  logic          sck_i,
  input  logic          fs_i,
  input  logic          sd_i,
  input  side_t         side_i,
  input  logic          drop_i,
  output logic          bnd_o,
  output logic          busy_o,
  output logic [DW-1:0] word_o,
  output logic          left_o,
  output side_t         side_o,
  output logic          valid_o
);
  localparam int CW = $clog2(DW + SLACK) + 1;
  localparam int IW = $clog2(DW);

  logic          sck_d, fs_last, busy_q, cur_left;
  logic [CW-1:0] n_q, k, pos, lj_idx;
  logic          act, rise_md, bnd, lj_hit, side_hit;
  logic [DW-1:0] sr_q, sr_nxt, base, out_w;
  side_t         side_w;

  always_comb begin
    rise_md = mode_i inside {FMT_MSTR, FMT_LJ, FMT_WCLK, FMT_I2S};
    act     = rise_md ? (sck_i & ~sck_d) : (~sck_i & sck_d);
    if (mode_i == FMT_WCLK) bnd = act & fs_i & ~fs_last;
    else                    bnd = act & (fs_i ^ fs_last) & (mode_i != FMT_RSVD);
    k        = bnd ? '0 : n_q;
    pos      = (mode_i == FMT_I2S) ? k - CW'(1) : k;
    lj_hit   = ((mode_i != FMT_I2S) || (k != '0)) && (pos < CW'(DW));
    lj_idx   = CW'(DW - 1) - pos;
    side_hit = (k == ((mode_i == FMT_I2S) ? CW'(1) : CW'(0)));
    base     = bnd ? '0 : sr_q;
    sr_nxt   = base;
    unique case (mode_i)
      FMT_RJ16, FMT_RJ18: sr_nxt = {base[DW-2:0], sd_i};
      FMT_LSBF:           sr_nxt = {sd_i, base[DW-1:1]};
      default:            if (lj_hit) sr_nxt[lj_idx[IW-1:0]] = sd_i;
    endcase
    unique case (mode_i)
      FMT_RJ16: out_w = sr_q << (DW - RJ_A);
      FMT_RJ18: out_w = sr_q << (DW - RJ_B);
      default:  out_w = sr_q;
    endcase
  end

  assign bnd_o  = bnd;
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d    <= 1'b0;
      fs_last  <= 1'b0;
      n_q      <= '0;
      sr_q     <= '0;
      side_w   <= '0;
      busy_q   <= 1'b0;
      cur_left <= 1'b0;
      word_o   <= '0;
      left_o   <= 1'b0;
      side_o   <= '0;
      valid_o  <= 1'b0;
    end else begin
      sck_d   <= sck_i;
      valid_o <= 1'b0;
      if (act) begin
        fs_last <= fs_i;
        n_q     <= bnd ? CW'(1) : ((&n_q) ? n_q : n_q + 1'b1);
        sr_q    <= sr_nxt;
        if (side_hit) side_w <= side_i;
      end
      if (bnd) begin
        if (busy_q && !drop_i) begin
          valid_o <= 1'b1;
          word_o  <= out_w;
          left_o  <= cur_left;
          side_o  <= side_w;
        end
        busy_q <= 1'b1;
        unique case (mode_i)
          FMT_WCLK: cur_left <= ~cur_left;
          FMT_I2S:  cur_left <= ~fs_i;
          default:  cur_left <= fs_i;
        endcase
      end
    end
  end

  // R9
  strobe_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R9
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(word_o));
  // R8
  rsvd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == FMT_RSVD && $past(mode_i) == FMT_RSVD) |-> !valid_o);
  // R5
  rj_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(mode_i) == FMT_RJ16) |-> (word_o[DW-RJ_A-1:0] == '0));
endmodule

// File: rtl/audin_port.sv
module audin_port
  import audin_pkg::*;
#(
  parameter int DW   = 24,
  parameter int HALF = 2,
  parameter int SLOT = 32,
  parameter int GW   = 10,
  parameter int TOL  = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    mode_i,
  input  logic          sck_i,
  input  logic          fs_i,
  input  logic          sd_i,
  input  logic          c_i,
  input  logic          u_i,
  input  logic          v_i,
  output logic          sck_o,
  output logic          fs_o,
  output logic          drive_en_o,
  output logic [DW-1:0] word_o,
  output logic          left_o,
  output logic          c_o,
  output logic          u_o,
  output logic          v_o,
  output logic          word_valid_o
);
  fmt_e  mode;
  logic  mstr, gen_sck, gen_fs;
  logic  sck_q, fs_q, sd_q, bnd, busy, drop;
  side_t side_q, side_out;

  assign mode       = fmt_e'(mode_i);
  assign mstr       = (mode == FMT_MSTR);
  assign drive_en_o = mstr;
  assign sck_o      = gen_sck;
  assign fs_o       = gen_fs;
  assign c_o        = side_out.c;
  assign u_o        = side_out.u;
  assign v_o        = side_out.v;

  audin_mstr_gen #(.HALF(HALF), .SLOT(SLOT)) u_gen (
    .clk_i, .rst_ni, .en_i(mstr), .sck_o(gen_sck), .fs_o(gen_fs)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q  <= 1'b0;
      fs_q   <= 1'b0;
      sd_q   <= 1'b0;
      side_q <= '0;
    end else begin
      sck_q  <= mstr ? gen_sck : sck_i;
      fs_q   <= mstr ? gen_fs : fs_i;
      sd_q   <= sd_i;
      side_q <= '{c: c_i, u: u_i, v: v_i};
    end
  end

  audin_jit_mon #(.GW(GW), .TOL(TOL)) u_jit (
    .clk_i, .rst_ni, .bnd_i(bnd), .busy_i(busy), .drop_o(drop)
  );

  audin_deser #(.DW(DW)) u_deser (
    .clk_i, .rst_ni, .mode_i(mode), .sck_i(sck_q), .fs_i(fs_q), .sd_i(sd_q),
    .side_i(side_q), .drop_i(drop), .bnd_o(bnd), .busy_o(busy),
    .word_o, .left_o, .side_o(side_out), .valid_o(word_valid_o)
  );
endmodule

// File: tb/audin_port_bench.sv
module audin_port_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic [2:0] mode = 3'd1;
  logic sck = 1'b0, fs = 1'b0, sd = 1'b0, c = 1'b0, u = 1'b0, v = 1'b0;
  logic sck_o, fs_o, drive_en_o, left_o, c_o, u_o, v_o, word_valid_o;
  logic [23:0] word_o;

  audin_port u_audin_port (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .sck_i(sck), .fs_i(fs), .sd_i(sd),
    .c_i(c), .u_i(u), .v_i(v), .sck_o, .fs_o, .drive_en_o, .word_o, .left_o,
    .c_o, .u_o, .v_o, .word_valid_o
  );

  int n_chk = 0, n_fail = 0, cap_total = 0;
  logic [23:0] cw [64];
  logic        cl [64];
  logic [2:0]  cs [64];
  bit done = 1'b0;

  always @(negedge clk) if (word_valid_o) begin
    cw[cap_total % 64] = word_o;
    cl[cap_total % 64] = left_o;
    cs[cap_total % 64] = {c_o, u_o, v_o};
    cap_total = cap_total + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expw(input int idx, input logic [23:0] w, input logic l, input string tag);
    chk(cw[idx % 64] == w, {tag, " word"}, {8'h0, cw[idx % 64]}, {8'h0, w});
    chk(cl[idx % 64] == l, {tag, " left"}, {31'h0, cl[idx % 64]}, {31'h0, l});
  endtask

  task automatic do_reset(input logic [2:0] m);
    rst_n = 1'b0; mode = m; sck = (m inside {3'd5, 3'd6, 3'd7}); fs = 1'b0; sd = 1'b0;
    {c, u, v} = 3'b000;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input logic fsv, input logic [2:0] side);
    logic inact;
    inact = (mode inside {3'd5, 3'd6, 3'd7});
    sck = inact;
    @(negedge clk);
    sd = b; fs = fsv; {c, u, v} = side;
    @(negedge clk);
    sck = ~inact;
    @(negedge clk);
    sd = ~b;
    @(negedge clk);
  endtask

  task automatic send_slot(input logic fsv, input int nfs, input logic [31:0] bits, input int nbits,
                           input logic [2:0] side0, input logic [2:0] side1);
    for (int i = 0; i < nbits; i++)
      send_bit(bits[31-i], (i < nfs) ? fsv : ~fsv, (i == 0) ? side0 : ((i == 1) ? side1 : 3'b000));
  endtask

  function automatic logic [23:0] rev24(input logic [23:0] d);
    for (int i = 0; i < 24; i++) rev24[i] = d[23-i];
  endfunction

  task automatic t_reset();
    do_reset(3'd1);
    chk(word_valid_o == 1'b0, "R9 reset strobe", {31'h0, word_valid_o}, 0);
    chk(word_o == 24'h0, "R9 reset word", {8'h0, word_o}, 0);
    chk(drive_en_o == 1'b0, "R1 slave drive", {31'h0, drive_en_o}, 0);
  endtask

  task automatic t_master();
    logic [31:0] lb, rb;
    logic ps, pf;
    int idx, last_rise, per, rises, hr, base;
    lb = {24'hA5C3F0, 8'h00}; rb = {24'h1E2D3C, 8'hFF};
    do_reset(3'd0);
    base = cap_total;
    chk(drive_en_o == 1'b1, "R1 master drive", {31'h0, drive_en_o}, 1);
    ps = sck_o; pf = fs_o; idx = 32; last_rise = -1; per = 0; rises = 0; hr = 0;
    for (int t = 0; t < 128 * 8; t++) begin
      @(negedge clk);
      if (sck_o && !ps) begin
        if (last_rise >= 0) per = t - last_rise;
        last_rise = t;
        rises++;
      end
      if (!sck_o && ps) begin
        if (fs_o != pf) begin hr = rises; rises = 0; idx = 0; end
        if (idx < 32) begin sd = fs_o ? lb[31-idx] : rb[31-idx]; idx++; end
      end
      ps = sck_o; pf = fs_o;
    end
    chk(per == 4, "R1 sck period", per, 4);
    chk(hr == 32, "R1 bits per half", hr, 32);
    chk(cap_total - base >= 2, "R1 master words", cap_total - base, 2);
    expw(base, 24'hA5C3F0, 1'b1, "R1 R3 master left");
    expw(base + 1, 24'h1E2D3C, 1'b0, "R1 R3 master right");
  endtask

  task automatic t_lj();
    int base;
    do_reset(3'd1);
    base = cap_total;
    send_slot(1'b1, 32, {24'hC0FFEE, 8'hFF}, 32, 3'b100, 3'b011);
    send_slot(1'b0, 32, {16'hBEAD, 16'h0000}, 32, 3'b000, 3'b000);
    send_slot(1'b1, 32, {24'h123456, 8'h00}, 32, 3'b000, 3'b000);
    send_slot(1'b0, 32, 32'h0, 32, 3'b000, 3'b000);
    chk(cap_total - base == 3, "R9 lj count", cap_total - base, 3);
    expw(base, 24'hC0FFEE, 1'b1, "R2 R3 lj 24 bit tail ignored");
    expw(base + 1, 24'hBEAD00, 1'b0, "R3 lj 16 bit zero fill");
    expw(base + 2, 24'h123456, 1'b1, "R9 lj third");
    chk(cs[base % 64] == 3'b100, "R10 side first period", {29'h0, cs[base % 64]}, 3'b100);
  endtask

  task automatic t_i2s();
    int base;
    do_reset(3'd4);
    base = cap_total;
    send_slot(1'b1, 32, 32'h0, 32, 3'b000, 3'b000);
    send_slot(1'b0, 32, {1'b1, 24'h6B2D91, 7'h7F}, 32, 3'b010, 3'b101);
    send_slot(1'b1, 32, {1'b0, 24'h3C0FF0, 7'h00}, 32, 3'b000, 3'b000);
    send_slot(1'b0, 32, 32'h0, 32, 3'b000, 3'b000);
    chk(cap_total - base == 3, "R4 i2s count", cap_total - base, 3);
    expw(base + 1, 24'h6B2D91, 1'b1, "R4 i2s left");
    expw(base + 2, 24'h3C0FF0, 1'b0, "R4 i2s right");
    chk(cs[(base + 1) % 64] == 3'b101, "R10 i2s side second period", {29'h0, cs[(base + 1) % 64]}, 3'b101);
  endtask

  task automatic t_rj();
    int base;
    do_reset(3'd5);
    base = cap_total;
    send_slot(1'b1, 32, {16'hFFFF, 16'hBEEF}, 32, 3'b000, 3'b000);
    send_slot(1'b0, 32, {16'h0000, 16'h1234}, 32, 3'b000, 3'b000);
    send_slot(1'b1, 32, 32'h0, 32, 3'b000, 3'b000);
    expw(base, 24'hBEEF00, 1'b1, "R2 R5 rj16 left");
    expw(base + 1, 24'h123400, 1'b0, "R5 rj16 right");
    do_reset(3'd6);
    base = cap_total;
    send_slot(1'b1, 32, {14'h3FFF, 18'h2ABCD}, 32, 3'b000, 3'b000);
    send_slot(1'b0, 32, 32'h0, 32, 3'b000, 3'b000);
    expw(base, 24'hAAF340, 1'b1, "R5 rj18");
  endtask

  task automatic t_lsbf();
    int base;
    do_reset(3'd7);
    base = cap_total;
    send_slot(1'b1, 32, {8'hFF, rev24(24'h13579B)}, 32, 3'b000, 3'b000);
    send_slot(1'b0, 32, {8'hFF, rev24(24'h00C0DE)}, 32, 3'b000, 3'b000);
    send_slot(1'b1, 32, 32'h0, 32, 3'b000, 3'b000);
    expw(base, 24'h13579B, 1'b1, "R6 lsb first");
    expw(base + 1, 24'h00C0DE, 1'b0, "R6 lsb first leading zeros");
  endtask

  task automatic t_wclk();
    int base;
    do_reset(3'd2);
    base = cap_total;
    send_slot(1'b1, 8, {24'h5A5A5A, 8'h00}, 32, 3'b000, 3'b000);
    send_slot(1'b1, 8, {24'hF0E1D2, 8'h00}, 32, 3'b000, 3'b000);
    send_slot(1'b1, 8, {24'h0F1E2D, 8'h00}, 32, 3'b000, 3'b000);
    send_slot(1'b1, 8, 32'h0, 32, 3'b000, 3'b000);
    chk(cap_total - base == 3, "R7 wclk count", cap_total - base, 3);
    expw(base, 24'h5A5A5A, 1'b1, "R7 wclk first");
    expw(base + 1, 24'hF0E1D2, 1'b0, "R7 wclk second");
    expw(base + 2, 24'h0F1E2D, 1'b1, "R7 wclk third");
  endtask

  task automatic t_rsvd();
    int base;
    do_reset(3'd3);
    base = cap_total;
    for (int s = 0; s < 4; s++) send_slot(s[0], 32, 32'hDEADBEEF, 32, 3'b111, 3'b111);
    chk(cap_total == base, "R8 reserved silent", cap_total - base, 0);
  endtask

  task automatic t_jit();
    int base;
    do_reset(3'd1);
    base = cap_total;
    send_slot(1'b1, 32, {24'hAAAA01, 8'h0}, 32, 3'b000, 3'b000);
    send_slot(1'b0, 32, {24'hBBBB02, 8'h0}, 31, 3'b000, 3'b000);
    send_slot(1'b1, 32, {24'hCCCC03, 8'h0}, 32, 3'b000, 3'b000);
    send_slot(1'b0, 32, {24'hDDDD04, 8'h0}, 32, 3'b000, 3'b000);
    send_slot(1'b1, 32, 32'h0, 32, 3'b000, 3'b000);
    chk(cap_total - base == 2, "R11 jitter count", cap_total - base, 2);
    expw(base, 24'hAAAA01, 1'b1, "R11 before slip");
    expw(base + 1, 24'hDDDD04, 1'b0, "R11 after resync");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_master();
    t_lj();
    t_i2s();
    t_rj();
    t_lsbf();
    t_wclk();
    t_rsvd();
    t_jit();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule